// File: doc/BRIEF.md
# BCH Sector Bit-Flip Corrector

This block sits after a BCH4 or BCH8 sector decoder and repairs a 512-byte sector held in a byte-wide buffer. After a start pulse it waits for the decoder's ready flag. It then captures one status word and four packed position words. If the status reports correctable errors, it walks the listed bit positions in order. For each position it reads the addressed byte, inverts one bit and writes the byte back. At the end it reports success, an uncorrectable sector, or a timeout when the ready flag never came.

A reported position can point past the data bytes, into the spare-area code bytes. Such a position is dropped with no buffer access.

The block also gives the spare-area code length for the chosen strength and bus width. Firmware uses this length to step through the spare area.

Top module: `bch_flip_applier`

## Requirements
- R1: After reset, `done` and `busy` are low and neither memory strobe is asserted. While `busy` is low, neither strobe is ever asserted.
- R2: The status word fields are:
  - bit 1 is the error-found flag;
  - bit 0 is the uncorrectable flag;
  - bits [7:4] are the error count.

  When the error-found flag is 0, the result is OK (code 0) and no write takes place, whatever the other fields hold.
- R3: When the error-found flag is 1, the result is BAD (code 1) with no writes in either of these cases:
  - the uncorrectable flag is 1;
  - the count is greater than 8.
- R4: Position word k, for k from 0 to 3, carries list entry 2k in bits [12:0] and list entry 2k+1 in bits [28:16]. The four words are packed into `pos_words` with word k at bits [32k+31:32k]. Only entries 0 to count-1 are used, in ascending order. A count of 0 gives OK with no writes.
- R5: Each applied position costs exactly two cycles:
  - a read strobe with the byte address;
  - in the next cycle, a write strobe to the same address.

  The read strobe and the write strobe are never high together.
- R6: For an applied position p, the byte address is p/8. The written byte is the read byte with only bit p mod 8 inverted. Listing a position twice restores the original byte.
- R7: A position of 4096 or more (past 512 × 8 data bits) is skipped with no memory access. The other entries are still applied.
- R8: If the ready flag is not seen within WAIT_LIMIT cycles after the start is accepted, the result is TIMEOUT (code 2) with no writes.
- R9: `code_bytes` is 7 for BCH4 and 13 for BCH8 (`strength8` = 1), plus 1 when `bus16` is 1.
- R10: `done` is a one-cycle pulse that marks the final `result`. `busy` is high from the cycle after an accepted start until `done`.
- R11: A start pulse while `busy` is high is ignored, so one job gives exactly one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a correction job (one-cycle pulse) |
| dec_ready | input | 1 | Decoder status valid |
| stat_word | input | 32 | Decoder flag word |
| pos_words | input | 128 | Four packed position words |
| strength8 | input | 1 | 1 selects BCH8, 0 selects BCH4 |
| bus16 | input | 1 | 16-bit flash bus in use |
| code_bytes | output | 4 | Spare-area code length in bytes |
| mem_rd_en | output | 1 | Sector buffer read strobe |
| mem_wr_en | output | 1 | Sector buffer write strobe |
| mem_addr | output | 9 | Sector buffer byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid the cycle after the read strobe |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job finished (one-cycle pulse) |
| result | output | 2 | 0 OK, 1 BAD, 2 TIMEOUT |

## Verification
The flip path is tried with several status and position patterns, and each one separates a different fault:
- A clean status that carries garbage in its other fields shows whether the found flag gates everything.
- An uncorrectable flag, and separately a count of nine, show the two BAD paths.
- A short in-range list, with the sector compared byte by byte, shows the address and bit arithmetic.
- A full list of eight mixing out-of-range and duplicate positions shows list order, count limiting, range skipping and cancelling flips.
- A zero count, a never-asserted ready flag and a second start during a job cover the remaining edges.
- All four strength and bus combinations of the code length are checked.

// File: rtl/bch_flip_applier.sv
module bch_flip_applier #(
  parameter int SECTOR_BYTES = 512,
  parameter int POS_W        = 13,
  parameter int POS_SLOTS    = 8,
  parameter int WAIT_LIMIT   = 4096
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   dec_ready,
  input  logic [31:0]            stat_word,
  input  logic [127:0]           pos_words,
  input  logic                   strength8,
  input  logic                   bus16,
  output logic [3:0]             code_bytes,
  output logic                   mem_rd_en,
  output logic                   mem_wr_en,
  output logic [8:0]             mem_addr,
  output logic [7:0]             mem_wdata,
  input  logic [7:0]             mem_rdata,
  output logic                   busy,
  output logic                   done,
  output logic [1:0]             result
);
  localparam int ADDR_W    = $clog2(SECTOR_BYTES);
  localparam int DATA_BITS = SECTOR_BYTES * 8;
  localparam int SL_W      = $clog2(POS_SLOTS);
  localparam int IDX_W     = $clog2(POS_SLOTS + 1);
  localparam int WCNT_W    = $clog2(WAIT_LIMIT + 1);

  localparam logic [1:0] RES_OK   = 2'd0;
  localparam logic [1:0] RES_BAD  = 2'd1;
  localparam logic [1:0] RES_TOUT = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_EVAL, S_SCAN, S_WRITE} state_t;

  state_t                     state;
  logic [WCNT_W-1:0]          wait_cnt;
  logic [7:0]                 flags_q;
  logic [POS_W-1:0]           pos_in [POS_SLOTS];
  logic [POS_W-1:0]           pos_q  [POS_SLOTS];
  logic [IDX_W-1:0]           idx;
  logic [ADDR_W-1:0]          addr_q;
  logic [2:0]                 bit_q;

  for (genvar g = 0; g < POS_SLOTS; g++) begin : g_unpack
    assign pos_in[g] = pos_words[(g/2)*32 + (g%2)*16 +: POS_W];
  end

  assign code_bytes = (strength8 ? 4'd13 : 4'd7) + {3'd0, bus16};

  logic             found, uncorr, list_end, in_range;
  logic [3:0]       err_cnt;
  logic [POS_W-1:0] cur_pos;

  assign uncorr   = flags_q[0];
  assign found    = flags_q[1];
  assign err_cnt  = flags_q[7:4];
  assign cur_pos  = pos_q[idx[SL_W-1:0]];
  assign list_end = 32'(idx) >= 32'(err_cnt);
  assign in_range = 32'(cur_pos) < DATA_BITS;

  assign busy      = state != S_IDLE;
  assign mem_rd_en = (state == S_SCAN) && !list_end && in_range;
  assign mem_wr_en = state == S_WRITE;
  assign mem_addr  = (state == S_WRITE) ? 9'(addr_q) : 9'(cur_pos[ADDR_W+2:3]);
  assign mem_wdata = mem_rdata ^ (8'd1 << bit_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      wait_cnt <= '0;
      flags_q  <= '0;
      idx      <= '0;
      addr_q   <= '0;
      bit_q    <= '0;
      done     <= 1'b0;
      result   <= RES_OK;
      for (int i = 0; i < POS_SLOTS; i++) pos_q[i] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state    <= S_WAIT;
          wait_cnt <= '0;
        end
        S_WAIT: begin
          if (dec_ready) begin
            flags_q <= stat_word[7:0];
            for (int i = 0; i < POS_SLOTS; i++) pos_q[i] <= pos_in[i];
            state   <= S_EVAL;
          end else if (32'(wait_cnt) == WAIT_LIMIT - 1) begin
            done   <= 1'b1;
            result <= RES_TOUT;
            state  <= S_IDLE;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        S_EVAL: begin
          idx <= '0;
          if (!found) begin
            done   <= 1'b1;
            result <= RES_OK;
            state  <= S_IDLE;
          end else if (uncorr || 32'(err_cnt) > POS_SLOTS) begin
            done   <= 1'b1;
            result <= RES_BAD;
            state  <= S_IDLE;
          end else begin
            state <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (list_end) begin
            done   <= 1'b1;
            result <= RES_OK;
            state  <= S_IDLE;
          end else if (in_range) begin
            addr_q <= cur_pos[ADDR_W+2:3];
            bit_q  <= cur_pos[2:0];
            state  <= S_WRITE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_WRITE: begin
          idx   <= idx + 1'b1;
          state <= S_SCAN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd_en && !mem_wr_en); // R1
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)); // R5
  AST_RMW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> mem_wr_en && mem_addr == $past(mem_addr)); // R5
  AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $countones(mem_wdata ^ mem_rdata) == 1); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
endmodule

// File: tb/sim_bch_flip_applier.sv
module sim_bch_flip_applier;
  localparam int WL = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, dec_ready = 1'b0, strength8 = 1'b0, bus16 = 1'b0;
  logic [31:0]  stat_word = '0;
  logic [127:0] pos_words = '0;
  logic [3:0]   code_bytes;
  logic         mem_rd_en, mem_wr_en, busy, done;
  logic [8:0]   mem_addr;
  logic [7:0]   mem_wdata, mem_rdata;
  logic [1:0]   result;

  always #2.5 clk = ~clk;

  bch_flip_applier #(.WAIT_LIMIT(WL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dec_ready(dec_ready),
    .stat_word(stat_word), .pos_words(pos_words), .strength8(strength8),
    .bus16(bus16), .code_bytes(code_bytes), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .result(result));

  logic [7:0] mem [512];
  logic [7:0] exp_mem [512];
  int wr_seen = 0;
  int checks = 0, fails = 0;

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_wr_en) begin
      mem[mem_addr] <= mem_wdata;
      wr_seen = wr_seen + 1;
    end
  end

  typedef struct { logic [1:0] res; int nwr; string tag; } item_t;
  item_t q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pop and compare on every done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (q.size() == 0) check(0, "R11 unexpected done", 1, 0);
        else begin
          item_t it;
          int bad;
          it = q.pop_front();
          check(result == it.res, {it.tag, " result"}, int'(result), int'(it.res));
          check(wr_seen == it.nwr, {it.tag, " write count"}, wr_seen, it.nwr);
          bad = 0;
          for (int i = 0; i < 512; i++) if (mem[i] !== exp_mem[i]) bad++;
          check(bad == 0, {it.tag, " sector bytes differing"}, bad, 0);
        end
      end
    end
  end

  function automatic logic [127:0] pack(input int p [8]);
    logic [127:0] w = '0;
    for (int k = 0; k < 8; k++) w[(k/2)*32 + (k%2)*16 +: 13] = 13'(p[k]);
    return w;
  endfunction

  // driver: compute the expected outcome from the rules, push it, run the job
  task automatic run_case(input logic [31:0] st, input int p [8], input int delay,
                          input bit restart, input string tag);
    item_t it;
    int n;
    n = int'(st[7:4]);
    it.tag = tag;
    it.nwr = 0;
    if (delay < 0) it.res = 2'd2;
    else if (!st[1]) it.res = 2'd0;
    else if (st[0] || n > 8) it.res = 2'd1;
    else begin
      it.res = 2'd0;
      for (int i = 0; i < n; i++)
        if (p[i] < 4096) begin
          exp_mem[p[i] / 8] = exp_mem[p[i] / 8] ^ (8'd1 << (p[i] % 8));
          it.nwr++;
        end
    end
    @(negedge clk);
    stat_word = st;
    pos_words = pack(p);
    wr_seen = 0;
    q.push_back(it);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (delay >= 0) begin
      for (int i = 0; i < delay; i++) begin
        @(negedge clk);
        if (restart && i == 0) start = 1'b1;
        else start = 1'b0;
      end
      start = 1'b0;
      dec_ready = 1'b1;
    end
    while (!done) @(negedge clk);
    dec_ready = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int p [8];
    repeat (3) @(negedge clk);
    check(!done && !busy && !mem_rd_en && !mem_wr_en, "R1 reset outputs", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1 idle after reset", int'(busy), 0);

    strength8 = 0; bus16 = 0; #1 check(code_bytes == 7,  "R9 bch4 8bit",  code_bytes, 7);
    bus16 = 1;                #1 check(code_bytes == 8,  "R9 bch4 16bit", code_bytes, 8);
    strength8 = 1; bus16 = 0; #1 check(code_bytes == 13, "R9 bch8 8bit",  code_bytes, 13);
    bus16 = 1;                #1 check(code_bytes == 14, "R9 bch8 16bit", code_bytes, 14);

    p = '{5, 100, 4000, 3, 7, 8, 9, 10};
    run_case(32'h0000_0031, p, 2, 0, "R2 found clear");
    run_case(32'h0000_0033, p, 1, 0, "R3 uncorrectable");
    run_case(32'h0000_0092, p, 0, 0, "R3 count nine");
    run_case(32'h0000_0002, p, 3, 0, "R4 count zero");

    p = '{0, 4095, 1234, 77, 77, 77, 77, 77};
    run_case(32'h0000_0032, p, 1, 0, "R6 three in range");

    p = '{4096, 17, 8191, 17, 2049, 4100, 511, 3000};
    run_case(32'h0000_0082, p, 4, 0, "R7 skip and duplicate");

    p = '{8, 9, 10, 11, 12, 13, 14, 15};
    run_case(32'h0000_0052, p, 0, 0, "R4 partial list");

    run_case(32'h0000_0012, p, -1, 0, "R8 timeout");

    p = '{1, 2, 3, 4, 5, 6, 7, 40};
    run_case(32'h0000_0022, p, 5, 1, "R11 start while busy");
    run_case(32'h0000_0012, p, 0, 0, "R5 single position");

    repeat (20) @(negedge clk);
    check(q.size() == 0, "R10 all jobs completed", q.size(), 0);
    check(!busy, "R10 idle at end", int'(busy), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule